// File: doc/BRIEF.md
# RTC Alarm and Event Interrupt Unit

This block sits beside a real-time timekeeper. The timekeeper presents the current time as six BCD fields (seconds, minutes, hours, day, month, year) and pulses a one-cycle update strobe each time the time advances by one second. On every strobe the unit works out which calendar boundaries the new time has crossed. It records them as sticky status flags: second, minute, hour and day. It also compares the new time against six programmable alarm registers and records a match.

A host reaches the unit through a simple synchronous register bus. The bus has a write strobe, an address and write data, and the read data is combinational. Through this bus the host programs the alarm time, inspects the flags and acknowledges them by writing ones to the status register. A power-up flag is raised by reset and stays raised until the host acknowledges it. It tells software that the timekeeping domain has lost state.

An interrupt control register picks one of the four periodic flags as the timer interrupt source and holds separate enables for the timer and alarm sources. The single level interrupt output stays asserted as long as an enabled flag is set. It therefore falls only when the host clears that flag or its enable.

Top module: `rtc_evt_irq`

## Requirements
- R1: After reset the status register (0x0E) reads 0x80, the interrupt control register (0x0F) reads 0x00, all six alarm registers read 0x00 and irq_o is low.
- R2: Alarm registers sit at 0x07 (seconds), 0x08 (minutes), 0x09 (hours), 0x0A (day), 0x0B (month) and 0x0C (year). Each reads back the last 8-bit value written to it. Every address other than 0x07..0x0C, 0x0E and 0x0F reads 0x00, and a write there changes no register.
- R3: On each update strobe the status register sets bit 2 (second event). It sets bit 3 when the new seconds field is 0x00, bit 4 when seconds and minutes are both 0x00, and bit 5 when seconds, minutes and hours are all 0x00. Status bits 1:0 always read 0.
- R4: Status bit 6 (alarm) is set on an update strobe when all six time inputs equal the six alarm registers. A time that matches without a strobe does not set it, and a strobe with any one field different does not set it.
- R5: Status flags are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A flag that is set by a strobe in the same cycle as a clearing write ends up set.
- R6: Status bit 7 (power-up) is set only by reset. It stays set until the host writes 1 to it and is never set again by any other activity.
- R7: Interrupt control register 0x0F holds a period select in bits 1:0 (00 second, 01 minute, 10 hour, 11 day), a timer enable in bit 2 and an alarm enable in bit 3. Bits 7:4 read 0.
- R8: irq_o equals (alarm flag AND alarm enable) OR (selected periodic flag AND timer enable). It follows register changes in the same cycle and stays high until the responsible flag or enable is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe: time inputs hold a newly advanced time |
| sec_i | input | 8 | BCD seconds of the current time |
| min_i | input | 8 | BCD minutes |
| hour_i | input | 8 | BCD hours |
| day_i | input | 8 | BCD day of month |
| mon_i | input | 8 | BCD month |
| year_i | input | 8 | BCD year |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is an arbitrary mix of set and clear flags. The strobe sets them in a fixed hierarchy: a day event always brings hour, minute and second events with it. The bench therefore programs the alarm to a midnight time and strobes exactly that time, which raises all five event flags at once. It then clears a chosen subset with one write-one-to-clear pattern. Repeating this over all 32 flag patterns, each crossed with all 16 interrupt control values, covers the interrupt selection exhaustively. A second hard case is a strobe and a clearing write arriving in the same cycle. The bench drives both in one task, so the two land on the same edge.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned NUM_PER    = 4;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned ALARM_BASE = 7;
  localparam int unsigned STAT_ADDR  = 14;
  localparam int unsigned CTRL_ADDR  = 15;

  typedef logic [FIELD_W-1:0] bcd_t;

  // Boundary events implied by a freshly advanced time.
  // bit0 second, bit1 minute, bit2 hour, bit3 day
  function automatic logic [NUM_PER-1:0] boundary_events(bcd_t s, bcd_t m, bcd_t h);
    logic [NUM_PER-1:0] ev;
    ev[0] = 1'b1;
    ev[1] = (s == '0);
    ev[2] = ev[1] && (m == '0);
    ev[3] = ev[2] && (h == '0);
    return ev;
  endfunction

  // Pick the periodic flag chosen by the period select field.
  function automatic logic pick_period(logic [1:0] sel, logic [NUM_PER-1:0] flags);
    return flags[sel];
  endfunction
endpackage

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank
  import rtc_evt_pkg::*;
#(
  parameter int unsigned FIELDS = NUM_FIELDS,
  parameter int unsigned DW     = FIELD_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned BASE   = ALARM_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [FIELDS*DW-1:0] time_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 match_o
);
  logic [DW-1:0]     alm_q [FIELDS];
  logic [FIELDS-1:0] hit;
  logic [FIELDS-1:0] field_eq;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    localparam logic [AW-1:0] MY_ADDR = AW'(BASE + g);
    assign hit[g]      = (addr_i == MY_ADDR);
    assign field_eq[g] = (alm_q[g] == time_i[g*DW +: DW]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               alm_q[g] <= '0;
      else if (we_i && hit[g])  alm_q[g] <= wdata_i;
    end

    // R2: an alarm field changes only on a write to its own address
    p_alarm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && hit[g]) |=> $stable(alm_q[g]));
  end

  assign match_o = &field_eq;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < FIELDS; i++)
      if (hit[i]) rdata_o = alm_q[i];
  end

  // R2: at most one alarm field answers any address
  p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
  import rtc_evt_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NPER = NUM_PER,
  parameter int unsigned ADDR = STAT_ADDR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [NPER-1:0] bound_i,
  input  logic            match_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPER+1:0] wdata_i,   // bus bits 7:2
  output logic [NPER-1:0] per_o,
  output logic            alarm_o,
  output logic            pup_o,
  output logic [7:0]      rdata_o
);
  localparam logic [AW-1:0] MY_ADDR = AW'(ADDR);

  logic [NPER-1:0] per_q, per_set, per_clr;
  logic            alm_q, alm_set, alm_clr;
  logic            pup_q, pup_clr;
  logic            sel;

  assign sel     = (addr_i == MY_ADDR);
  assign per_set = tick_i ? bound_i : '0;
  assign alm_set = tick_i && match_i;
  assign per_clr = (we_i && sel) ? wdata_i[NPER-1:0] : '0;
  assign alm_clr = we_i && sel && wdata_i[NPER];
  assign pup_clr = we_i && sel && wdata_i[NPER+1];

  for (genvar g = 0; g < NPER; g++) begin : g_per
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_q[g] <= 1'b0;
      else        per_q[g] <= per_set[g] | (per_q[g] & ~per_clr[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= 1'b0;
      pup_q <= 1'b1;
    end else begin
      alm_q <= alm_set | (alm_q & ~alm_clr);
      pup_q <= pup_q & ~pup_clr;
    end
  end

  assign per_o   = per_q;
  assign alarm_o = alm_q;
  assign pup_o   = pup_q;
  assign rdata_o = sel ? {pup_q, alm_q, per_q, 2'b00} : 8'h00;

  // R6: once cleared the power-up flag never returns
  p_pup_stays_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pup_q |=> !pup_q);
  // R5: a set alarm flag survives any cycle without a clearing write
  p_alarm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_q && !alm_clr |=> alm_q);
  // R5: a set request wins over a simultaneous clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_set |=> alm_q);
  // R5: a clearing write without a new match drops the flag
  p_clear_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_clr && !alm_set |=> !alm_q);
  // R4: the alarm flag cannot rise without a strobe
  p_alarm_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_q && !tick_i |=> !alm_q);
  // R3: every strobe records a second event
  p_sec_each_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> per_q[0]);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_evt_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NPER = NUM_PER,
  parameter int unsigned ADDR = CTRL_ADDR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [3:0]      wdata_i,
  input  logic [NPER-1:0] per_i,
  input  logic            alarm_i,
  output logic            irq_o,
  output logic [7:0]      rdata_o
);
  localparam logic [AW-1:0] MY_ADDR = AW'(ADDR);

  logic [3:0] ctl_q;
  logic       sel, tmr_src, tmr_req, alm_req;

  assign sel = (addr_i == MY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctl_q <= '0;
    else if (we_i && sel) ctl_q <= wdata_i;
  end

  assign tmr_src = pick_period(ctl_q[1:0], per_i);
  assign tmr_req = tmr_src && ctl_q[2];
  assign alm_req = alarm_i && ctl_q[3];
  assign irq_o   = tmr_req || alm_req;
  assign rdata_o = sel ? {4'h0, ctl_q} : 8'h00;

  // R7: control register moves only on its own write
  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && sel) |=> $stable(ctl_q));
  // R8: an enabled alarm flag keeps the line up
  p_alarm_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_i && ctl_q[3] |-> irq_o);
  // R8: with both enables off the line is quiet
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[2] && !ctl_q[3] |-> !irq_o);
endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic [DW-1:0] day_i,
  input  logic [DW-1:0] mon_i,
  input  logic [DW-1:0] year_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  output logic          irq_o
);
  localparam int unsigned TW = NUM_FIELDS * DW;

  logic [TW-1:0]      time_flat;
  logic [NUM_PER-1:0] bound;
  logic               alarm_match;
  logic [NUM_PER-1:0] per_flags;
  logic               alarm_flag, pup_flag;
  logic [7:0]         rd_alm, rd_stat, rd_ctl;

  assign time_flat = {year_i, mon_i, day_i, hour_i, min_i, sec_i};
  assign bound     = boundary_events(sec_i, min_i, hour_i);

  rtc_alarm_bank #(.FIELDS(NUM_FIELDS), .DW(DW), .AW(AW), .BASE(ALARM_BASE)) u_alarm (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i[DW-1:0]), .time_i(time_flat),
    .rdata_o(rd_alm), .match_o(alarm_match));

  rtc_status_flags #(.AW(AW), .NPER(NUM_PER), .ADDR(STAT_ADDR)) u_flags (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bound_i(bound),
    .match_i(alarm_match), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i[7:2]), .per_o(per_flags), .alarm_o(alarm_flag),
    .pup_o(pup_flag), .rdata_o(rd_stat));

  rtc_irq_ctrl #(.AW(AW), .NPER(NUM_PER), .ADDR(CTRL_ADDR)) u_irq (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i[3:0]), .per_i(per_flags), .alarm_i(alarm_flag),
    .irq_o(irq_o), .rdata_o(rd_ctl));

  assign bus_rdata_o = rd_alm | rd_stat | rd_ctl;

  // R3: a day event is always accompanied by an hour event
  p_day_implies_hour_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && bound[3] |=> per_flags[2]);
  // R8: with no flag standing the interrupt is low
  p_no_flag_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flags == '0) && !alarm_flag |-> !irq_o);
  // R6: power-up flag is never raised outside reset
  p_pup_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pup_flag));
endmodule

// File: tb/test_rtc_evt_irq.sv
module test_rtc_evt_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] t_s = 8'h01, t_m = 8'h01, t_h = 8'h01, t_d = 8'h01, t_mo = 8'h01, t_y = 8'h99;
  logic       we = 1'b0;
  logic [4:0] addr = 5'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  rtc_evt_irq i_rtc_evt_irq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .sec_i(t_s), .min_i(t_m), .hour_i(t_h), .day_i(t_d), .mon_i(t_mo), .year_i(t_y),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y);
    t_s = s; t_m = m; t_h = h; t_d = d; t_mo = mo; t_y = y;
  endtask

  // strobe the current time; optionally clear all status in the same cycle
  task automatic strobe(input logic with_clear);
    @(negedge clk);
    tick = 1'b1;
    if (with_clear) begin we = 1'b1; addr = 5'h0E; wdata = 8'hFF; end
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
  endtask

  task automatic set_alarm(input logic [7:0] s, m, h, d, mo, y);
    wr(5'h07, s); wr(5'h08, m); wr(5'h09, h);
    wr(5'h0A, d); wr(5'h0B, mo); wr(5'h0C, y);
  endtask

  logic [7:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R6 power-up flag present
    rd(5'h0E, v); check(v, 8'h80, "R1/R6 status after reset");
    rd(5'h0F, v); check(v, 8'h00, "R1 control after reset");
    for (int i = 7; i <= 12; i++) begin
      rd(5'(i), v); check(v, 8'h00, "R1 alarm field after reset");
    end
    check({7'd0, irq}, 8'h00, "R1 irq after reset");

    // R2 alarm fields read back distinct values
    for (int i = 0; i < 6; i++) wr(5'(7 + i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 6; i++) begin
      rd(5'(7 + i), v); check(v, 8'(8'h11 * (i + 1)), "R2 alarm readback");
    end
    // R2 unmapped addresses: writes ignored and read zero
    for (int a = 0; a < 32; a++) begin
      if (!((a >= 7 && a <= 12) || a == 14 || a == 15)) begin
        wr(5'(a), 8'hA5);
        rd(5'(a), v); check(v, 8'h00, "R2 unmapped reads zero");
      end
    end
    for (int i = 0; i < 6; i++) begin
      rd(5'(7 + i), v); check(v, 8'(8'h11 * (i + 1)), "R2 alarm untouched by stray writes");
    end
    rd(5'h0F, v); check(v, 8'h00, "R2 control untouched by stray writes");

    // R5/R6: writing zeros keeps power-up; writing one clears it
    wr(5'h0E, 8'h7F);
    rd(5'h0E, v); check(v, 8'h80, "R5 zero write keeps flag");
    wr(5'h0E, 8'h80);
    rd(5'h0E, v); check(v, 8'h00, "R6 power-up cleared");

    // R3 boundary sweep; alarm year 0x66 never matches year 0x99
    for (int c = 0; c < 8; c++) begin
      for (int k = 1; k <= 3; k++) begin
        logic [7:0] s, m, h, e;
        s = c[0] ? 8'h00 : 8'(8'h10 * k + 8'h09);
        m = c[1] ? 8'h00 : 8'(8'h10 * k);
        h = c[2] ? 8'h00 : 8'(k + 1);
        set_time(s, m, h, 8'h15, 8'h06, 8'h99);
        strobe(1'b0);
        e = 8'h04;
        if (s == 0) e |= 8'h08;
        if (s == 0 && m == 0) e |= 8'h10;
        if (s == 0 && m == 0 && h == 0) e |= 8'h20;
        rd(5'h0E, v); check(v, e, "R3 boundary events");
        wr(5'h0E, 8'hFF);
        rd(5'h0E, v); check(v, 8'h00, "R5 all flags cleared");
      end
    end
    // R6: activity did not raise power-up again
    rd(5'h0E, v); check(v & 8'h80, 8'h00, "R6 power-up stays clear");

    // R4 alarm match
    set_alarm(8'h30, 8'h45, 8'h12, 8'h28, 8'h02, 8'h24);
    set_time(8'h30, 8'h45, 8'h12, 8'h28, 8'h02, 8'h24);
    repeat (3) @(negedge clk);
    rd(5'h0E, v); check(v, 8'h00, "R4 match without strobe ignored");
    for (int f = 0; f < 6; f++) begin
      set_time(f == 0 ? 8'h31 : 8'h30, f == 1 ? 8'h46 : 8'h45, f == 2 ? 8'h13 : 8'h12,
               f == 3 ? 8'h29 : 8'h28, f == 4 ? 8'h03 : 8'h02, f == 5 ? 8'h25 : 8'h24);
      strobe(1'b0);
      rd(5'h0E, v); check(v & 8'h40, 8'h00, "R4 one field differs");
      wr(5'h0E, 8'hFF);
    end
    set_time(8'h30, 8'h45, 8'h12, 8'h28, 8'h02, 8'h24);
    strobe(1'b0);
    rd(5'h0E, v); check(v, 8'h44, "R4 full match sets alarm");
    // R5 sticky over further non-matching strobes
    set_time(8'h31, 8'h45, 8'h12, 8'h28, 8'h02, 8'h24);
    strobe(1'b0);
    rd(5'h0E, v); check(v, 8'h44, "R5 alarm sticky");
    wr(5'h0E, 8'h04);
    rd(5'h0E, v); check(v, 8'h40, "R5 clear only written bit");
    wr(5'h0E, 8'hFF);
    // R5 set wins over simultaneous clear
    set_time(8'h30, 8'h45, 8'h12, 8'h28, 8'h02, 8'h24);
    strobe(1'b1);
    rd(5'h0E, v); check(v, 8'h44, "R5 set beats same-cycle clear");

    // R8 level behaviour: alarm interrupt held until flag cleared
    wr(5'h0F, 8'h08);
    check({7'd0, irq}, 8'h01, "R8 alarm irq asserted");
    set_time(8'h33, 8'h45, 8'h12, 8'h28, 8'h02, 8'h24);
    for (int n = 0; n < 3; n++) strobe(1'b0);
    check({7'd0, irq}, 8'h01, "R8 alarm irq held");
    wr(5'h0E, 8'h40);
    check({7'd0, irq}, 8'h00, "R8 irq drops after alarm clear");
    wr(5'h0F, 8'hFF);
    rd(5'h0F, v); check(v, 8'h0F, "R7 upper control bits read zero");
    wr(5'h0F, 8'h00);
    wr(5'h0E, 8'hFF);

    // R7/R8 exhaustive: 32 flag patterns x 16 control values
    set_alarm(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    for (int p = 0; p < 32; p++) begin
      set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
      strobe(1'b0);
      rd(5'h0E, v); check(v, 8'h7C, "R3/R4 midnight raises all events");
      wr(5'h0E, 8'((~p & 5'h1F) << 2));
      rd(5'h0E, v); check(v, 8'(p << 2), "R5 selective clear pattern");
      for (int c = 0; c < 16; c++) begin
        logic e;
        wr(5'h0F, 8'(c));
        e = (p[4] && c[3]) || (p[c[1:0]] && c[2]);
        check({7'd0, irq}, {7'd0, e}, "R8 irq combination");
        if (p == 0) begin
          rd(5'h0F, v); check(v, 8'(c), "R7 control readback");
        end
      end
      wr(5'h0F, 8'h00);
      wr(5'h0E, 8'hFF);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule